// File: doc/BRIEF.md
# Dual-Framing Serial Command Receiver

This block takes write-only serial traffic from a host microcontroller and turns each completed frame into a byte, a data/command tag and a single-cycle valid pulse on the system clock. The host lowers an active-low select line, toggles a serial clock, and presents one bit per rising serial clock edge, most significant bit first. No read path exists.

A static strap input selects the framing. With the strap low, each frame is eight bits and a separate data/command pin gives the tag. With the strap high, each frame is nine bits and the first bit carries the tag in-band. All serial inputs pass through a two-stage synchronizer. The block samples the serial clock with the system clock, so the serial clock must stay high and low for at least two system clock cycles each.

Top module: `serial_cmd_rx`

## Requirements
- R1: `mode_3w` low selects 8-bit frames tagged by `dc_pin`. `mode_3w` high selects 9-bit frames tagged in-band, and `dc_pin` then has no effect.
- R2: While `cs_n` is high, serial clock edges shift nothing and `rx_valid` stays low.
- R3: `sdin` is sampled on each rising `sclk` edge. The first payload bit lands in `rx_byte[7]` and the last lands in `rx_byte[0]`.
- R4: In 8-bit framing, `rx_is_data` is the level of `dc_pin` at the rising edge of the eighth bit (1 = data, 0 = command). Its level at earlier bits does not matter.
- R5: In 9-bit framing, the first bit of the frame becomes `rx_is_data` (1 = data, 0 = command), and the next eight bits form `rx_byte`, MSB first.
- R6: If `cs_n` goes high before a frame completes, the partial frame is dropped and the next frame starts counting from its first bit.
- R7: Each completed frame gives exactly one `rx_valid` pulse of one system clock cycle. `rx_byte` and `rx_is_data` change only in that cycle and hold their values otherwise.
- R8: Several frames sent back to back under one low `cs_n` period each produce their own pulse, in order.
- R9: After reset, `rx_valid`, `rx_byte` and `rx_is_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| dc_pin | input | 1 | Data (1) / command (0) tag, used in 8-bit framing only |
| mode_3w | input | 1 | Framing strap: 0 = 8-bit with tag pin, 1 = 9-bit in-band tag |
| rx_byte | output | 8 | Last received byte |
| rx_is_data | output | 1 | Tag of the last received byte (1 = data) |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |

## Verification
Asymmetric bytes such as A5, 3C, 81 and 7E are sent so that bit-order mistakes and tag inversions show up as wrong values. In 8-bit framing, `dc_pin` is changed just before the last bit, which separates sampling at the last bit from sampling at any earlier bit. In 9-bit framing, `dc_pin` is held at the level opposite to the in-band tag, which shows the pin is ignored. A frame aborted after five bits and then followed by a full frame checks that the counter restarts. Clock toggling with select high, and two frames under one select, check the select gating and the frame-to-frame rollover.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shift;
        logic              tag;
        logic              sclk_prev;
        logic [BYTE_W-1:0] out_byte;
        logic              out_tag;
        logic              out_valid;
    } framer_state_t;
endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : gen_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= din;
                end else begin
                    stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx_framer.sv
module serial_cmd_rx_framer
    import serial_cmd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    input  logic              dc_s,
    input  logic              mode_s,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_tag,
    output logic              out_valid
);
    localparam logic [CNT_W-1:0] LAST_4W = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_3W = CNT_W'(BYTE_W);

    framer_state_t st_d, st_q;
    logic          rise;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s && !st_q.sclk_prev && !cs_s;
        last_idx       = mode_s ? LAST_3W : LAST_4W;

        if (cs_s) begin
            st_d.cnt = '0;
        end else if (rise) begin
            if (mode_s && st_q.cnt == '0) begin
                st_d.tag = sdin_s;
            end else begin
                st_d.shift = {st_q.shift[BYTE_W-2:0], sdin_s};
            end

            if (st_q.cnt == last_idx) begin
                st_d.cnt       = '0;
                st_d.out_byte  = {st_q.shift[BYTE_W-2:0], sdin_s};
                st_d.out_tag   = mode_s ? st_q.tag : dc_s;
                st_d.out_valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte  = st_q.out_byte;
    assign out_tag   = st_q.out_tag;
    assign out_valid = st_q.out_valid;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import serial_cmd_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              dc_pin,
    input  logic              mode_3w,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              rx_valid
);
    localparam int NSIG = 5;

    logic [NSIG-1:0] raw, synced;

    assign raw = {mode_3w, dc_pin, sdin, sclk, cs_n};

    serial_cmd_rx_sync #(
        .WIDTH  (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(NSIG'(1))
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    serial_cmd_rx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (synced[0]),
        .sclk_s   (synced[1]),
        .sdin_s   (synced[2]),
        .dc_s     (synced[3]),
        .mode_s   (synced[4]),
        .out_byte (rx_byte),
        .out_tag  (rx_is_data),
        .out_valid(rx_valid)
    );
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       dc_pin,
    input logic       mode_3w,
    input logic [7:0] rx_byte,
    input logic       rx_is_data,
    input logic       rx_valid
);
    localparam int LAT = SYNC_STAGES + 1;

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_byte) && $stable(rx_is_data)));

    // R2
    select_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(cs_n, LAT));

    // R4
    tag_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(mode_3w, LAT)) |-> (rx_is_data == $past(dc_pin, LAT)));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (!rx_valid && rx_byte == 8'h00 && !rx_is_data);
        end
    end
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dc_pin    (dc_pin),
    .mode_3w   (mode_3w),
    .rx_byte   (rx_byte),
    .rx_is_data(rx_is_data),
    .rx_valid  (rx_valid)
);

// File: tb/tb_serial_cmd_rx.sv
`timescale 1ns/1ps
module tb_serial_cmd_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       dc_pin = 1'b0;
    logic       mode_3w = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_is_data;
    logic       rx_valid;

    int checks = 0;
    int fails  = 0;
    int cap_n  = 0;
    logic [7:0] cap_byte [16];
    logic       cap_tag  [16];

    always #2 clk = ~clk;

    serial_cmd_rx dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .dc_pin(dc_pin), .mode_3w(mode_3w), .rx_byte(rx_byte),
        .rx_is_data(rx_is_data), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid && cap_n < 16) begin
            cap_byte[cap_n] = rx_byte;
            cap_tag[cap_n]  = rx_is_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic sbit(input logic b);
        sdin = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic dc_early, input logic dc_last);
        dc_pin = dc_early;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) dc_pin = dc_last;
            sbit(b[i]);
        end
    endtask

    task automatic begin_frame();
        cap_n = 0;
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_frame();
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic test_reset();
        check("R9 valid", rx_valid, 0);
        check("R9 byte", rx_byte, 0);
        check("R9 tag", rx_is_data, 0);
    endtask

    task automatic test_4w_basic();
        mode_3w = 1'b0;
        wait_clk(8);
        begin_frame();
        send_byte(8'hA5, 1'b0, 1'b0);
        end_frame();
        check("R1 R3 count", cap_n, 1);
        check("R3 byte", cap_byte[0], 8'hA5);
        check("R4 command tag", cap_tag[0], 0);
        begin_frame();
        send_byte(8'h3C, 1'b1, 1'b1);
        end_frame();
        check("R3 byte", cap_byte[0], 8'h3C);
        check("R4 data tag", cap_tag[0], 1);
    endtask

    task automatic test_4w_dc_late();
        begin_frame();
        send_byte(8'h0F, 1'b0, 1'b1);
        end_frame();
        check("R4 late high count", cap_n, 1);
        check("R4 late high tag", cap_tag[0], 1);
        begin_frame();
        send_byte(8'hF0, 1'b1, 1'b0);
        end_frame();
        check("R4 late low tag", cap_tag[0], 0);
        check("R4 late low byte", cap_byte[0], 8'hF0);
    endtask

    task automatic test_3w();
        mode_3w = 1'b1;
        wait_clk(8);
        begin_frame();
        sbit(1'b1);
        send_byte(8'h81, 1'b0, 1'b0);
        end_frame();
        check("R5 count", cap_n, 1);
        check("R5 byte", cap_byte[0], 8'h81);
        check("R5 R1 data tag ignores pin", cap_tag[0], 1);
        begin_frame();
        sbit(1'b0);
        send_byte(8'h7E, 1'b1, 1'b1);
        end_frame();
        check("R5 byte", cap_byte[0], 8'h7E);
        check("R5 R1 command tag ignores pin", cap_tag[0], 0);
    endtask

    task automatic test_abort();
        mode_3w = 1'b0;
        wait_clk(8);
        begin_frame();
        for (int i = 0; i < 5; i++) sbit(1'b1);
        end_frame();
        check("R6 partial dropped", cap_n, 0);
        begin_frame();
        send_byte(8'h5A, 1'b1, 1'b1);
        end_frame();
        check("R6 restart count", cap_n, 1);
        check("R6 restart byte", cap_byte[0], 8'h5A);
    endtask

    task automatic test_deselected();
        cap_n = 0;
        for (int i = 0; i < 12; i++) sbit(1'b1);
        wait_clk(8);
        check("R2 no pulse while deselected", cap_n, 0);
        check("R2 byte unchanged", rx_byte, 8'h5A);
    endtask

    task automatic test_back_to_back();
        begin_frame();
        send_byte(8'h12, 1'b0, 1'b0);
        send_byte(8'hC9, 1'b1, 1'b1);
        end_frame();
        check("R8 R7 two pulses", cap_n, 2);
        check("R8 first byte", cap_byte[0], 8'h12);
        check("R8 first tag", cap_tag[0], 0);
        check("R8 second byte", cap_byte[1], 8'hC9);
        check("R8 second tag", cap_tag[1], 1);
    endtask

    initial begin
        wait_clk(3);
        test_reset();
        rst_n = 1'b1;
        wait_clk(4);
        test_4w_basic();
        test_4w_dc_late();
        test_3w();
        test_abort();
        test_deselected();
        test_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule